// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch is taken. In the first execute step of a branch, the operand register is driven onto the data bus and the condition field is presented. The block tests the bus value against the selected condition and captures the one-bit verdict in an internal flag when the flag-load strobe is high. Software cannot read or write this flag.

In the following step, the control unit raises the target strobe while the branch target is on the bus. The block passes that strobe through to the program-counter load enable only when the captured flag is set. The register file, the program counter and the bus drivers sit outside the block.

The 3-bit condition field selects one of six tests: never, always, operand zero, operand nonzero, sign bit clear and sign bit set. The two unused codes always give a false result. The zero test is a wide NOR of the bus, built as a tree of group ORs.

Top module: `brcond_unit`

## Requirements
- R1: With `cond_sel` = 0, a flag load leaves the flag at 0, whatever the bus value.
- R2: With `cond_sel` = 1, a flag load sets the flag to 1, whatever the bus value.
- R3: With `cond_sel` = 2, a flag load sets the flag to 1 exactly when all 32 bits of `bus_data` are 0.
- R4: With `cond_sel` = 3, a flag load sets the flag to 1 exactly when at least one bit of `bus_data` is 1.
- R5: With `cond_sel` = 4, a flag load sets the flag to 1 exactly when `bus_data[31]` is 0.
- R6: With `cond_sel` = 5, a flag load sets the flag to 1 exactly when `bus_data[31]` is 1.
- R7: With `cond_sel` = 6 or 7, a flag load leaves the flag at 0.
- R8: Reset clears the flag. After reset, `tgt_strobe` alone gives `pc_load_en` = 0.
- R9: While `flag_load` is low, the flag keeps its value. Changes on `bus_data` and `cond_sel` do not affect it.
- R10: `pc_load_en` equals `tgt_strobe` AND the flag, in the same cycle, with no register on the path. It is 0 whenever `tgt_strobe` is low.
- R11: The flag changes at the clock edge that samples `flag_load`. If `flag_load` and `tgt_strobe` are high in the same cycle, `pc_load_en` follows the flag value from before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_data | input | 32 | Operand or branch target from the data bus |
| cond_sel | input | 3 | Condition field (low three bits of the instruction) |
| flag_load | input | 1 | Capture the evaluated condition into the flag at the next edge |
| tgt_strobe | input | 1 | Branch-target step strobe |
| pc_load_en | output | 1 | Program-counter load enable, the strobe gated by the flag |

## Verification
The clocked properties assume that `bus_data` and `cond_sel` are stable and known at every edge where `flag_load` is high. They also assume that no load is expected to take effect until the internal reset has been released. The bench changes inputs only on the falling edge. After reset it waits several cycles before the first load. It reads the flag only through `pc_load_en`, raising `tgt_strobe` a half cycle after each load edge.

// File: rtl/brc_pkg.sv
`timescale 1ns/1ps
package brc_pkg;
  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CC_NEVER   = 3'd0,
    CC_ALWAYS  = 3'd1,
    CC_ZERO    = 3'd2,
    CC_NONZERO = 3'd3,
    CC_SGN_CLR = 3'd4,
    CC_SGN_SET = 3'd5
  } cond_code_e;
endpackage

// File: rtl/brc_rst_sync.sv
`timescale 1ns/1ps
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/brc_zero_detect.sv
`timescale 1ns/1ps
module brc_zero_detect #(
  parameter int WIDTH = 32,
  parameter int GROUP = 8
) (
  input  logic [WIDTH-1:0] data,
  output logic             is_zero
);
  localparam int NGRP  = (WIDTH + GROUP - 1) / GROUP;
  localparam int PAD_W = NGRP * GROUP;

  logic [PAD_W-1:0] padded;
  logic [NGRP-1:0]  grp_any;

  always_comb begin
    padded = '0;
    padded[WIDTH-1:0] = data;
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |padded[g*GROUP +: GROUP];
  end

  assign is_zero = ~|grp_any;
endmodule

// File: rtl/brc_cond_select.sv
`timescale 1ns/1ps
module brc_cond_select import brc_pkg::*; (
  input  logic [COND_W-1:0] sel,
  input  logic              is_zero,
  input  logic              sign,
  output logic              hit
);
  always_comb begin
    case (cond_code_e'(sel))
      CC_NEVER:   hit = 1'b0;
      CC_ALWAYS:  hit = 1'b1;
      CC_ZERO:    hit = is_zero;
      CC_NONZERO: hit = ~is_zero;
      CC_SGN_CLR: hit = ~sign;
      CC_SGN_SET: hit = sign;
      default:    hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brcond_unit.sv
`timescale 1ns/1ps
module brcond_unit import brc_pkg::*; #(
  parameter int DATA_W      = 32,
  parameter int ZGROUP      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [COND_W-1:0] cond_sel,
  input  logic              flag_load,
  input  logic              tgt_strobe,
  output logic              pc_load_en
);
  localparam int SIGN_BIT = DATA_W - 1;

  logic rst_q;
  logic bus_zero;
  logic cond_hit;
  logic flag_d;
  logic flag_q;

  brc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  brc_zero_detect #(.WIDTH(DATA_W), .GROUP(ZGROUP)) u_zero (
    .data    (bus_data),
    .is_zero (bus_zero)
  );

  brc_cond_select u_sel (
    .sel     (cond_sel),
    .is_zero (bus_zero),
    .sign    (bus_data[SIGN_BIT]),
    .hit     (cond_hit)
  );

  // next state of the hidden flag: explicit load enable
  always_comb flag_d = flag_load ? cond_hit : flag_q;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign pc_load_en = tgt_strobe & flag_q;

  // ---------------- assertions ----------------
  p_never_r1: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd0) |=> !flag_q);
  p_always_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd1) |=> flag_q);
  p_zero_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd2) |=> (flag_q == ($past(bus_data) == '0)));
  p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd3) |=> (flag_q == ($past(bus_data) != '0)));
  p_sign_clear_r5: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd4) |=> (flag_q == !$past(bus_data[SIGN_BIT])));
  p_sign_set_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel == 3'd5) |=> (flag_q == $past(bus_data[SIGN_BIT])));
  p_spare_r7: assert property (@(posedge clk) disable iff (!rst_q)
    (flag_load && cond_sel[2:1] == 2'b11) |=> !flag_q);
  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_q |-> !pc_load_en);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_q)
    !flag_load |=> $stable(flag_q));
  p_gate_r10: assert property (@(posedge clk) disable iff (!rst_q)
    pc_load_en |-> tgt_strobe);
endmodule

// File: tb/brcond_unit_test.sv
`timescale 1ns/1ps
module brcond_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_data;
  logic [2:0]  cond_sel;
  logic        flag_load;
  logic        tgt_strobe;
  logic        pc_load_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  brcond_unit uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_data   (bus_data),
    .cond_sel   (cond_sel),
    .flag_load  (flag_load),
    .tgt_strobe (tgt_strobe),
    .pc_load_en (pc_load_en)
  );

  task automatic check(input logic got, input logic exp, input string req, input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: pc_load_en=%b expected %b", req, what, got, exp);
    end
  endtask

  // load flag with a condition, then probe it through the strobe next cycle
  task automatic load_probe(input logic [2:0] code, input logic [31:0] d,
                            input logic exp, input string req);
    @(negedge clk);
    cond_sel = code; bus_data = d; flag_load = 1'b1; tgt_strobe = 1'b0;
    @(negedge clk);
    flag_load = 1'b0; bus_data = 32'h1234_5678; tgt_strobe = 1'b1;
    #1 check(pc_load_en, exp, req, $sformatf("code %0d data %h", code, d));
    tgt_strobe = 1'b0;
    #0.5 check(pc_load_en, 1'b0, "R10", "strobe low");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bus_data = '0; cond_sel = 3'd1; flag_load = 1'b0; tgt_strobe = 1'b1;
    repeat (3) @(negedge clk);
    #1 check(pc_load_en, 1'b0, "R8", "during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1 check(pc_load_en, 1'b0, "R8", "after reset");
    tgt_strobe = 1'b0;
  endtask

  task automatic t_never;
    load_probe(3'd1, 32'h0, 1'b1, "R2");
    load_probe(3'd0, 32'h0, 1'b0, "R1");
    load_probe(3'd1, 32'h0, 1'b1, "R2");
    load_probe(3'd0, 32'hFFFF_FFFF, 1'b0, "R1");
  endtask

  task automatic t_always;
    load_probe(3'd1, 32'h8000_0000, 1'b1, "R2");
    load_probe(3'd1, 32'h0000_0001, 1'b1, "R2");
  endtask

  task automatic t_zero;
    load_probe(3'd2, 32'h0, 1'b1, "R3");
    load_probe(3'd2, 32'h0000_0100, 1'b0, "R3");
    load_probe(3'd2, 32'h0, 1'b1, "R3");
    load_probe(3'd2, 32'h8000_0000, 1'b0, "R3");
    for (int b = 0; b < 32; b += 7) load_probe(3'd2, 32'h1 << b, 1'b0, "R3");
  endtask

  task automatic t_nonzero;
    load_probe(3'd3, 32'h0, 1'b0, "R4");
    load_probe(3'd3, 32'h0000_0001, 1'b1, "R4");
    load_probe(3'd3, 32'h0, 1'b0, "R4");
    load_probe(3'd3, 32'h0040_0000, 1'b1, "R4");
  endtask

  task automatic t_sign_clear;
    load_probe(3'd4, 32'h7FFF_FFFF, 1'b1, "R5");
    load_probe(3'd4, 32'h8000_0000, 1'b0, "R5");
    load_probe(3'd4, 32'h0, 1'b1, "R5");
  endtask

  task automatic t_sign_set;
    load_probe(3'd5, 32'h8000_0000, 1'b1, "R6");
    load_probe(3'd5, 32'h7FFF_FFFF, 1'b0, "R6");
    load_probe(3'd5, 32'hFFFF_FFFF, 1'b1, "R6");
  endtask

  task automatic t_unused;
    load_probe(3'd1, 32'h0, 1'b1, "R2");
    load_probe(3'd6, 32'h0, 1'b0, "R7");
    load_probe(3'd1, 32'h0, 1'b1, "R2");
    load_probe(3'd7, 32'h8000_0000, 1'b0, "R7");
    load_probe(3'd7, 32'hFFFF_FFFF, 1'b0, "R7");
  endtask

  task automatic t_hold;
    load_probe(3'd1, 32'h0, 1'b1, "R9");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cond_sel = 3'(i); bus_data = 32'hDEAD_0000 + 32'(i); flag_load = 1'b0;
    end
    @(negedge clk);
    tgt_strobe = 1'b1;
    #1 check(pc_load_en, 1'b1, "R9", "set flag held");
    tgt_strobe = 1'b0;
    load_probe(3'd0, 32'h0, 1'b0, "R9");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cond_sel = 3'd1; bus_data = '0;
    end
    @(negedge clk);
    tgt_strobe = 1'b1;
    #1 check(pc_load_en, 1'b0, "R9", "clear flag held");
    tgt_strobe = 1'b0;
  endtask

  task automatic t_same_cycle;
    load_probe(3'd1, 32'h0, 1'b1, "R11");
    @(negedge clk);
    cond_sel = 3'd0; flag_load = 1'b1; tgt_strobe = 1'b1;
    #1 check(pc_load_en, 1'b1, "R11", "old flag before edge");
    @(negedge clk);
    flag_load = 1'b0;
    #1 check(pc_load_en, 1'b0, "R11", "new flag after edge");
    @(negedge clk);
    cond_sel = 3'd1; flag_load = 1'b1;
    #1 check(pc_load_en, 1'b0, "R10", "same cycle, flag still clear");
    @(negedge clk);
    flag_load = 1'b0;
    #1 check(pc_load_en, 1'b1, "R10", "combinational with strobe");
    tgt_strobe = 1'b0;
    #0.5 check(pc_load_en, 1'b0, "R10", "strobe dropped");
  endtask

  initial begin
    t_reset;
    t_never;
    t_always;
    t_zero;
    t_nonzero;
    t_sign_clear;
    t_sign_set;
    t_unused;
    t_hold;
    t_same_cycle;
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule